// File: doc/BRIEF.md
# Eight-Line GPIO Expander Register Core

This block holds the configuration and status registers of an eight-line general-purpose I/O expander, together with the logic that turns those registers into per-pin pad controls. A host reaches the registers over a simple synchronous bus: an 8-bit address, a write strobe, a read strobe, and 8-bit write and read data. A serial link target in front of the block turns transactions into this bus. Reads return data combinationally while the read strobe is high. Side effects of a read take place at the clock edge that ends the read cycle.

Each pin gets a drive value, a drive enable, a pull enable and a pull direction. Pin levels pass through a synchroniser before they are used. Each pin has a programmable expected level. When an unmasked pin differs from its expected level, that pin's sticky status bit is set, and one interrupt line reports any set bit. Reading the status register clears it. An identification register reports a fixed vendor code and a revision number. It also carries a reset-indication flag, which is cleared when the register is read, and a self-clearing software-reset bit.

Top module: `gpx_core`

## Requirements
- R1: After reset the registers read as follows: direction (0x03) = 0x00, drive value (0x05) = 0x00, release (0x07) = 0xFF, expected level (0x09) = 0xFF, pull enable (0x0B) = 0xFF, pull select (0x0D) = 0xFF, mask (0x11) = 0xFF, status (0x13) = 0x00. The interrupt output is low.
- R2: A read of 0x01 returns {3'b101, FW_REV[2:0], flag, 1'b0}. The flag is 1 after reset and becomes 0 at the edge that ends a read of 0x01. Bit 0 always reads 0.
- R3: A set direction bit makes that pin an output. pin_oe = direction & ~release. pin_out = drive value & pin_oe, so pin_out is 0 on any pin that is not being driven.
- R4: pull_en = pull enable & ~direction. pull_up = pull select & pull enable & ~direction, where a 1 on pull_up selects pull-up and a 0 selects pull-down. Pulls are therefore never active on output pins.
- R5: A read of 0x0F returns the pin levels through a two-flop synchroniser, with 1 meaning high. A level applied before clock edge n is returned after edge n+1 and not before that edge.
- R6: A status bit is set when the synchronised pin level differs from the expected-level bit and the mask bit is 0. A mask bit of 1 blocks that pin. Status bits stay set until the status register is read.
- R7: A read of 0x13 clears the whole register at the edge that ends the read. An event present during that read cycle leaves its bit set.
- R8: irq is high exactly when at least one status bit is set.
- R9: A write of 0x01 with bit 0 = 1 returns every register, the flag included, to its reset value at that edge. A write of 0x01 with bit 0 = 0 changes nothing.
- R10: Writes to 0x0F, 0x13 and unmapped addresses are ignored. Reads of unmapped addresses return 0x00, and bus_rdata is 0x00 while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Drive value per pin |
| pin_oe | output | 8 | Drive enable per pin |
| pull_en | output | 8 | Pull enable per pin |
| pull_up | output | 8 | Pull direction per pin, 1 = up |
| irq | output | 1 | Interrupt, OR of status bits |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle, and that the bus inputs only change away from the rising clock edge. The bench drives every bus transaction at the falling edge and holds it for one full cycle, and it never asserts both strobes at once. It changes pin levels only at falling edges. Before it predicts status values, it waits enough cycles for the synchroniser to settle. That way the level-based status bits depend only on the programmed expected levels and masks.

// File: rtl/gpx_pkg.sv
// Shared constants and types for the GPIO expander register core.
// Assumes an 8-bit register bus; all register widths equal DATA_W.
package gpx_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    // Register addresses (host software depends on these offsets)
    localparam logic [ADDR_W-1:0] A_IDENT  = 8'h01;
    localparam logic [ADDR_W-1:0] A_DIR    = 8'h03;
    localparam logic [ADDR_W-1:0] A_DRIVE  = 8'h05;
    localparam logic [ADDR_W-1:0] A_RELS   = 8'h07;
    localparam logic [ADDR_W-1:0] A_EXPECT = 8'h09;
    localparam logic [ADDR_W-1:0] A_PEN    = 8'h0B;
    localparam logic [ADDR_W-1:0] A_PSEL   = 8'h0D;
    localparam logic [ADDR_W-1:0] A_LEVEL  = 8'h0F;
    localparam logic [ADDR_W-1:0] A_MASK   = 8'h11;
    localparam logic [ADDR_W-1:0] A_STAT   = 8'h13;

    localparam logic [2:0] VENDOR_CODE = 3'b101;
    localparam int         SRST_BIT    = 0;

    // Power-on values
    localparam logic [DATA_W-1:0] ALL0 = '0;
    localparam logic [DATA_W-1:0] ALL1 = '1;

    typedef struct packed {
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] drive;
        logic [DATA_W-1:0] rels;
        logic [DATA_W-1:0] expect_lvl;
        logic [DATA_W-1:0] pen;
        logic [DATA_W-1:0] psel;
        logic [DATA_W-1:0] mask;
    } gpx_cfg_t;

    localparam gpx_cfg_t CFG_RESET = '{
        dir: ALL0, drive: ALL0, rels: ALL1, expect_lvl: ALL1,
        pen: ALL1, psel: ALL1, mask: ALL1
    };
endpackage

// File: rtl/gpx_sync.sv
// Multi-flop level synchroniser for the pin inputs.
// Assumes inputs idle high (pulled up), so flops reset to all ones.
module gpx_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the pin levels one stage further each clock
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '1;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
// Configuration register file, reset-indication flag and software reset.
// Assumes the bus never raises write and read strobes together.
module gpx_regs
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output gpx_cfg_t          cfg,
    output logic              flag,
    output logic              srst
);
    // Software reset request decoded from an identification write
    assign srst = wr && (addr == A_IDENT) && wdata[SRST_BIT];

    // Update the writable configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            cfg <= CFG_RESET;
        end else if (wr) begin
            case (addr)
                A_DIR:    cfg.dir        <= wdata;
                A_DRIVE:  cfg.drive      <= wdata;
                A_RELS:   cfg.rels       <= wdata;
                A_EXPECT: cfg.expect_lvl <= wdata;
                A_PEN:    cfg.pen        <= wdata;
                A_PSEL:   cfg.psel       <= wdata;
                A_MASK:   cfg.mask       <= wdata;
                default:  ;
            endcase
        end
    end

    // Reset-indication flag: set by any reset, cleared by reading identification
    always_ff @(posedge clk) begin
        if (!rst_n || srst)                 flag <= 1'b1;
        else if (rd && addr == A_IDENT)     flag <= 1'b0;
    end
endmodule

// File: rtl/gpx_irq.sv
// Sticky interrupt status: compares synchronised levels with expected levels.
// Assumes lvl is already synchronous to clk.
module gpx_irq
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              rd_stat,
    input  logic [DATA_W-1:0] lvl,
    input  logic [DATA_W-1:0] expect_lvl,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] stat,
    output logic [DATA_W-1:0] evt,
    output logic              irq
);
    // Unmasked pins currently away from their expected level
    assign evt = (lvl ^ expect_lvl) & ~mask;

    // Accumulate events; a read clears but same-cycle events survive
    always_ff @(posedge clk) begin
        if (!rst_n || srst) stat <= '0;
        else if (rd_stat)   stat <= evt;
        else                stat <= stat | evt;
    end

    // Single interrupt line from any pending status bit
    assign irq = |stat;
endmodule

// File: rtl/gpx_core.sv
// Top of the GPIO expander register core: bus decode, read mux, pad control.
// Assumes a host bus with one-cycle strobes and no simultaneous read/write.
module gpx_core
    import gpx_pkg::*;
#(
    parameter logic [2:0] FW_REV      = 3'd2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe,
    output logic [DATA_W-1:0] pull_en,
    output logic [DATA_W-1:0] pull_up,
    output logic              irq
);
    gpx_cfg_t          cfg_q;
    logic              rst_flag;
    logic              soft_rst;
    logic [DATA_W-1:0] lvl_sync;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] stat_evt;
    logic [DATA_W-1:0] ident;

    gpx_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_sync)
    );

    gpx_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .cfg(cfg_q), .flag(rst_flag), .srst(soft_rst)
    );

    gpx_irq u_irq (
        .clk(clk), .rst_n(rst_n), .srst(soft_rst),
        .rd_stat(bus_rd && bus_addr == A_STAT),
        .lvl(lvl_sync), .expect_lvl(cfg_q.expect_lvl), .mask(cfg_q.mask),
        .stat(stat_q), .evt(stat_evt), .irq(irq)
    );

    assign ident = {VENDOR_CODE, FW_REV, rst_flag, 1'b0};

    // Per-pin pad control derived from direction, release and pull settings
    for (genvar p = 0; p < DATA_W; p++) begin : g_pad
        always_comb begin
            pin_oe[p]  = cfg_q.dir[p] & ~cfg_q.rels[p];
            pin_out[p] = cfg_q.drive[p] & pin_oe[p];
            pull_en[p] = cfg_q.pen[p] & ~cfg_q.dir[p];
            pull_up[p] = cfg_q.psel[p] & pull_en[p];
        end
    end

    // Read data mux, zero when idle or unmapped
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_IDENT:  bus_rdata = ident;
                A_DIR:    bus_rdata = cfg_q.dir;
                A_DRIVE:  bus_rdata = cfg_q.drive;
                A_RELS:   bus_rdata = cfg_q.rels;
                A_EXPECT: bus_rdata = cfg_q.expect_lvl;
                A_PEN:    bus_rdata = cfg_q.pen;
                A_PSEL:   bus_rdata = cfg_q.psel;
                A_LEVEL:  bus_rdata = lvl_sync;
                A_MASK:   bus_rdata = cfg_q.mask;
                A_STAT:   bus_rdata = stat_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpx_core_chk.sv
// Property checker for gpx_core, attached by bind.
// Assumes the host never asserts bus_wr and bus_rd together.
module gpx_core_chk
    import gpx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] pin_oe,
    input logic [DATA_W-1:0] pull_en,
    input logic              irq,
    input logic [DATA_W-1:0] stat,
    input logic [DATA_W-1:0] evt,
    input logic [DATA_W-1:0] mask,
    input logic              flag
);
    // Pulls and drivers are never on together on one pin
    p_no_pull_on_output_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pull_en) == '0);

    // Masked pins never gain a status bit
    p_masked_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & $past(mask)) == '0));

    // After a status read only that cycle's events remain
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT) |=> ((stat & ~$past(evt)) == '0));

    // Interrupt line rises only with a pending status bit
    p_irq_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (stat != '0));

    // Reading identification clears the flag
    p_flag_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_IDENT) |=> !flag);

    // Software reset releases all drivers and clears the interrupt
    p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_IDENT && bus_wdata[SRST_BIT])
        |=> (!irq && pin_oe == '0 && flag));

    // Vendor code field on every identification read
    always_comb begin
        if (rst_n && bus_rd && bus_addr == A_IDENT)
            p_vendor_code_r2: assert (bus_rdata[7:5] == VENDOR_CODE && !bus_rdata[0]);
    end

    // Idle bus reads as zero
    always_comb begin
        if (rst_n && !bus_rd)
            p_idle_zero_r10: assert (bus_rdata == '0);
    end
endmodule

bind gpx_core gpx_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_oe(pin_oe), .pull_en(pull_en), .irq(irq), .stat(stat_q),
    .evt(stat_evt), .mask(cfg_q.mask), .flag(rst_flag)
);

// File: tb/tb_gpx_core.sv
module tb_gpx_core;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] bus_addr = 0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] pin_out, pin_oe, pull_en, pull_up;
    logic       irq;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model of the writable registers
    logic [7:0] m_dir, m_drv, m_rel, m_exp, m_pen, m_psel, m_mask;

    always #10 clk = ~clk;

    gpx_core dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pull_en(pull_en), .pull_up(pull_up), .irq(irq)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_dir = 8'h00; m_drv = 8'h00; m_rel = 8'hFF; m_exp = 8'hFF;
        m_pen = 8'hFF; m_psel = 8'hFF; m_mask = 8'hFF;
    endtask

    function automatic logic [7:0] f_oe();  return m_dir & ~m_rel;          endfunction
    function automatic logic [7:0] f_out(); return m_drv & f_oe();          endfunction
    function automatic logic [7:0] f_pe();  return m_pen & ~m_dir;          endfunction
    function automatic logic [7:0] f_pu();  return m_psel & f_pe();         endfunction

    // all tasks start and end at a falling edge
    task automatic wr(logic [7:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
        case (a)
            8'h03: m_dir = d;  8'h05: m_drv = d;  8'h07: m_rel = d;
            8'h09: m_exp = d;  8'h0B: m_pen = d;  8'h0D: m_psel = d;
            8'h11: m_mask = d;
            8'h01: if (d[0]) model_reset();
            default: ;
        endcase
    endtask

    task automatic rd(string req, logic [7:0] a, logic [7:0] exp);
        bus_addr = a; bus_rd = 1;
        #1 check(req, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic rd_any(logic [7:0] a);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic check_pads(string req);
        check({req, " oe"}, pin_oe, f_oe());
        check({req, " out"}, pin_out, f_out());
        check({req, " pen"}, pull_en, f_pe());
        check({req, " pup"}, pull_up, f_pu());
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] a, d;
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        model_reset();
        idle(3);
        rst_n = 1;
        @(negedge clk);

        // R1 reset values
        rd("R1", 8'h03, 8'h00); rd("R1", 8'h05, 8'h00); rd("R1", 8'h07, 8'hFF);
        rd("R1", 8'h09, 8'hFF); rd("R1", 8'h0B, 8'hFF); rd("R1", 8'h0D, 8'hFF);
        rd("R1", 8'h11, 8'hFF); rd("R1", 8'h13, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check_pads("R1");

        // R2 identification and flag
        rd("R2", 8'h01, 8'b101_010_1_0);
        rd("R2", 8'h01, 8'b101_010_0_0);

        // R3 drive control
        wr(8'h03, 8'hF0); wr(8'h05, 8'hAA);
        check_pads("R3");
        wr(8'h07, 8'h30);
        check("R3", pin_oe, 8'hC0); check("R3", pin_out, 8'h80);
        // R4 pulls
        wr(8'h0D, 8'h05);
        check("R4", pull_en, 8'h0F); check("R4", pull_up, 8'h05);
        check_pads("R4");

        // R5 synchroniser latency
        pin_in = 8'h5A;
        @(negedge clk);
        rd("R5 early", 8'h0F, 8'hFF);
        rd("R5 late", 8'h0F, 8'h5A);
        pin_in = 8'hFF; idle(3);

        // R6 / R7 / R8 directed
        wr(8'h11, 8'h00);
        rd("R6 none", 8'h13, 8'h00);
        pin_in = 8'hFE; idle(3);
        check("R8 irq", {7'b0, irq}, 8'h01);
        rd("R6 set", 8'h13, 8'h01);
        rd("R7 same-cycle kept", 8'h13, 8'h01);
        pin_in = 8'hFF; idle(3);
        rd("R6 sticky", 8'h13, 8'h01);
        rd("R7 cleared", 8'h13, 8'h00);
        check("R8 irq low", {7'b0, irq}, 8'h00);
        wr(8'h11, 8'h01);
        pin_in = 8'hFE; idle(3);
        rd("R6 masked", 8'h13, 8'h00);
        pin_in = 8'hFF; idle(3);

        // R10 ignored writes and unmapped reads
        wr(8'h0F, 8'h00); wr(8'h13, 8'hFF); wr(8'h20, 8'h77); wr(8'h02, 8'h55);
        rd("R10 level", 8'h0F, 8'hFF);
        rd("R10 stat", 8'h13, 8'h00);
        rd("R10 unmapped", 8'h20, 8'h00);
        rd("R10 unmapped", 8'h02, 8'h00);
        check("R10 idle", bus_rdata, 8'h00);

        // R9 software reset
        wr(8'h01, 8'hFE);
        rd("R9 no reset", 8'h03, 8'hF0);
        rd("R9 no reset flag", 8'h01, 8'b101_010_0_0);
        wr(8'h11, 8'h00); pin_in = 8'h00; idle(3);
        wr(8'h01, 8'h01);
        rd("R9 dir", 8'h03, 8'h00);
        rd("R9 rel", 8'h07, 8'hFF);
        rd("R9 mask", 8'h11, 8'hFF);
        rd("R9 flag", 8'h01, 8'b101_010_1_0);
        rd("R9 stat", 8'h13, 8'h00);
        check_pads("R9");

        // Random configuration and pin patterns
        for (int it = 0; it < 300; it++) begin
            for (int k = 0; k < 4; k++) begin
                a = 8'h03 + 8'(2 * ($urandom % 8));
                if (a == 8'h0F) a = 8'h11;
                d = 8'($urandom);
                wr(a, d);
            end
            pin_in = 8'($urandom);
            check_pads("R3R4 rand");
            idle(3);
            rd("R5 rand", 8'h0F, pin_in);
            rd_any(8'h13);
            check("R8 rand irq", {7'b0, irq}, {7'b0, |((pin_in ^ m_exp) & ~m_mask)});
            rd("R6R7 rand", 8'h13, (pin_in ^ m_exp) & ~m_mask);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule